// File: doc/BRIEF.md
# Symmetric Space-Vector Switching Sequencer

This block turns per-period dwell settings into a three-phase inverter switching pattern. A triangular time base counts from zero up to a programmed peak and back down. Two compare thresholds split the rising half into three parts: a first active vector, a second active vector and a zero vector. The falling half replays those parts in reverse order. The result is a pattern that is symmetric about the peak of the triangle.

Software computes the sector, the two adjacent active vector codes, which of them leads, and the two thresholds. It writes them in a single strobe. The values are held in staging registers and are only taken up when the counter passes through zero, so a period never mixes old and new settings. A strobe marks the start of each period so that software can prepare the next one.

The sequencer uses one zero vector per half period. It picks the zero vector that is one bit away from the active vector shown just before it. This keeps each transition to a single leg.

Top module: `svm_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `hs_o` is 000, `ls_o` is 111 and `pend_o` is 0. The staged and active settings all reset to zero, so the timer peak is 0.
- R2: With active peak P ≥ 1, the internal count runs 0,1,…,P,P−1,…,1 and repeats, so one period lasts 2P cycles. `pend_o` is high for exactly one cycle per period, in the cycle where `hs_o` shows the pattern for count 0. With P = 0, `pend_o` is high in every cycle.
- R3: Call the threshold values c1 and c2 and the count c. The pattern for count c is as follows. If c2 is valid and c ≥ c2, the pattern is the zero vector. Otherwise, if c1 is valid and c ≥ c1, the pattern is the second vector. Otherwise it is the first vector. The pattern depends only on c, so the rising and falling halves mirror each other.
- R4: The zero vector is 000 when the active vector shown just before it has at most one bit set, and 111 otherwise. That preceding vector is the second vector when c1 is valid and either c2 is invalid or c1 < c2; in every other case it is the first vector.
- R5: Of the two supplied codes `vec_a_i` and `vec_b_i`, the first vector is the numerically smaller when `ord_i` = 0 and the numerically larger when `ord_i` = 1. The second vector is the other code.
- R6: In every cycle, `ls_o` is the bitwise complement of `hs_o`.
- R7: A threshold is valid only when it is nonzero and strictly below P. An invalid threshold causes no transition, and the pattern in force before it is held.
- R8: `wr_i` captures all settings into staging registers. They become active at the next clock edge at which the count is 0. A write in the middle of a period leaves the rest of that period unchanged.
- R9: A write captured on the same edge as a reload is not used by that reload. The period that follows still runs the previous settings, and the new settings start one period later.
- R10: When both thresholds are valid and c1 ≥ c2, the zero vector takes priority and the second vector never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Strobe that captures all settings into staging |
| per_i | input | CW | Triangle peak value P |
| cmp1_i | input | CW | First threshold c1 |
| cmp2_i | input | CW | Second threshold c2 |
| vec_a_i | input | 3 | One adjacent active vector code |
| vec_b_i | input | 3 | The other adjacent active vector code |
| ord_i | input | 1 | 0: smaller code leads, 1: larger code leads |
| hs_o | output | 3 | High-side switch pattern (registered) |
| ls_o | output | 3 | Low-side switch pattern (registered) |
| pend_o | output | 1 | One-cycle period-start strobe |

## Verification
Two functions can fall in the same cycle: the reload at count zero, and a settings write that software times against `pend_o`. The bench triggers this overlap by raising `wr_i` in the last cycle of a period, so that the capture edge is also the reload edge. It then expects one more full period with the old settings before the new ones appear (R9). A write placed at the peak is checked the same way, against the following period (R8). The pattern itself is swept over every threshold pair, including zero and values at or above the peak, for small peaks, both orders and all six sectors.

// File: rtl/svm_pkg.sv
package svm_pkg;
  localparam int NPH = 3;

  typedef logic [NPH-1:0] vec_t;

  typedef struct packed {
    vec_t va;
    vec_t vb;
    logic ord;
  } vsel_t;

  // zero vector one bit away from the given active vector
  function automatic vec_t near_zero(input vec_t v);
    int n;
    n = 0;
    for (int i = 0; i < NPH; i++) n += int'(v[i]);
    return (n <= 1) ? vec_t'(0) : {NPH{1'b1}};
  endfunction
endpackage

// File: rtl/svm_stage.sv
module svm_stage
  import svm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] c1_i,
  input  logic [CW-1:0] c2_i,
  input  vsel_t         vs_i,
  input  logic          reload_i,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] c1_o,
  output logic [CW-1:0] c2_o,
  output vsel_t         vs_o
);
  logic [CW-1:0] sh_per, sh_c1, sh_c2;
  vsel_t         sh_vs;
  logic [CW-1:0] ac_per, ac_c1, ac_c2;
  vsel_t         ac_vs;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_per <= '0;
      sh_c1  <= '0;
      sh_c2  <= '0;
      sh_vs  <= '0;
    end else if (wr_i) begin
      sh_per <= per_i;
      sh_c1  <= c1_i;
      sh_c2  <= c2_i;
      sh_vs  <= vs_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_per <= '0;
      ac_c1  <= '0;
      ac_c2  <= '0;
      ac_vs  <= '0;
    end else if (reload_i) begin
      ac_per <= sh_per;
      ac_c1  <= sh_c1;
      ac_c2  <= sh_c2;
      ac_vs  <= sh_vs;
    end
  end

  // at the reload edge the staged values already steer the new period
  always_comb begin
    per_o = reload_i ? sh_per : ac_per;
    c1_o  = reload_i ? sh_c1  : ac_c1;
    c2_o  = reload_i ? sh_c2  : ac_c2;
    vs_o  = reload_i ? sh_vs  : ac_vs;
  end

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reload_i |=> ($stable(ac_per) && $stable(ac_c1) && $stable(ac_c2) && $stable(ac_vs)));
endmodule

// File: rtl/svm_timer.sv
module svm_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  logic          up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (cnt_q == '0) begin
      up_q  <= 1'b1;
      cnt_q <= (per_i == '0) ? '0 : CW'(1);
    end else if (up_q) begin
      if (cnt_q >= per_i) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R2
  peak_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q <= per_i));

  // R2
  rise_step_chk: assert property (@(posedge clk) disable iff (rst)
    (up_q && cnt_q != '0 && cnt_q < per_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2
  fall_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/svm_pattern.sv
module svm_pattern
  import svm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic          zero_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] c1_i,
  input  logic [CW-1:0] c2_i,
  input  vsel_t         vs_i,
  output vec_t          hs_o,
  output vec_t          ls_o,
  output logic          pend_o
);
  logic v1, v2;
  vec_t lo_v, hi_v, lead_v, trail_v, prev_v, zero_v, nxt;

  always_comb begin
    v1      = (c1_i != '0) && (c1_i < per_i);
    v2      = (c2_i != '0) && (c2_i < per_i);
    lo_v    = (vs_i.va < vs_i.vb) ? vs_i.va : vs_i.vb;
    hi_v    = (vs_i.va < vs_i.vb) ? vs_i.vb : vs_i.va;
    lead_v  = vs_i.ord ? hi_v : lo_v;
    trail_v = vs_i.ord ? lo_v : hi_v;
    prev_v  = (v1 && (!v2 || c1_i < c2_i)) ? trail_v : lead_v;
    zero_v  = near_zero(prev_v);
    if (v2 && cnt_i >= c2_i)      nxt = zero_v;
    else if (v1 && cnt_i >= c1_i) nxt = trail_v;
    else                          nxt = lead_v;
  end

  logic pend_q;
  vec_t hs_q, ls_q;

  for (genvar g = 0; g < NPH; g++) begin : g_leg
    always_ff @(posedge clk) begin
      if (rst) begin
        hs_q[g] <= 1'b0;
        ls_q[g] <= 1'b1;
      end else begin
        hs_q[g] <= nxt[g];
        ls_q[g] <= ~nxt[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= zero_i;
  end

  assign hs_o   = hs_q;
  assign ls_o   = ls_q;
  assign pend_o = pend_q;

  // R6
  compl_chk: assert property (@(posedge clk) disable iff (rst)
    ls_q == ~hs_q);

  // R3
  legal_pat_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!zero_i) |-> (hs_q == $past(lead_v) || hs_q == $past(trail_v) ||
                        hs_q == '0 || hs_q == '1));
endmodule

// File: rtl/svm_seq.sv
module svm_seq
  import svm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] cmp1_i,
  input  logic [CW-1:0] cmp2_i,
  input  logic [2:0]    vec_a_i,
  input  logic [2:0]    vec_b_i,
  input  logic          ord_i,
  output logic [2:0]    hs_o,
  output logic [2:0]    ls_o,
  output logic          pend_o
);
  logic [CW-1:0] e_per, e_c1, e_c2, cnt;
  vsel_t         e_vs, in_vs;
  logic          zero;

  assign in_vs = '{va: vec_a_i, vb: vec_b_i, ord: ord_i};

  svm_stage #(.CW(CW)) u_stage (
    .clk(clk), .rst(rst), .wr_i(wr_i),
    .per_i(per_i), .c1_i(cmp1_i), .c2_i(cmp2_i), .vs_i(in_vs),
    .reload_i(zero),
    .per_o(e_per), .c1_o(e_c1), .c2_o(e_c2), .vs_o(e_vs)
  );

  svm_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .per_i(e_per), .cnt_o(cnt), .zero_o(zero)
  );

  svm_pattern #(.CW(CW)) u_pat (
    .clk(clk), .rst(rst), .cnt_i(cnt), .zero_i(zero),
    .per_i(e_per), .c1_i(e_c1), .c2_i(e_c2), .vs_i(e_vs),
    .hs_o(hs_o), .ls_o(ls_o), .pend_o(pend_o)
  );
endmodule

// File: tb/sim_svm_seq.sv
module sim_svm_seq;
  localparam int CW = 8;

  typedef struct {
    int per, c1, c2, va, vb, ord;
  } prm_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_i = 1'b0;
  logic [CW-1:0] per_i = '0, cmp1_i = '0, cmp2_i = '0;
  logic [2:0]    vec_a_i = '0, vec_b_i = '0;
  logic          ord_i = 1'b0;
  logic [2:0]    hs_o, ls_o;
  logic          pend_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  svm_seq #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .wr_i(wr_i), .per_i(per_i), .cmp1_i(cmp1_i),
    .cmp2_i(cmp2_i), .vec_a_i(vec_a_i), .vec_b_i(vec_b_i), .ord_i(ord_i),
    .hs_o(hs_o), .ls_o(ls_o), .pend_o(pend_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    return (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1);
  endfunction

  // expected high-side pattern for count c under settings p
  function automatic int ref_pat(input prm_t p, input int c);
    bit v1, v2;
    int lo, hi, f, s, pre, z;
    v1  = (p.c1 != 0) && (p.c1 < p.per);
    v2  = (p.c2 != 0) && (p.c2 < p.per);
    lo  = (p.va < p.vb) ? p.va : p.vb;
    hi  = (p.va < p.vb) ? p.vb : p.va;
    f   = p.ord ? hi : lo;
    s   = p.ord ? lo : hi;
    pre = (v1 && (!v2 || p.c1 < p.c2)) ? s : f;
    z   = (ones(pre) <= 1) ? 0 : 7;
    if (v2 && c >= p.c2) return z;
    if (v1 && c >= p.c1) return s;
    return f;
  endfunction

  task automatic drive(input prm_t p);
    per_i   = CW'(p.per);
    cmp1_i  = CW'(p.c1);
    cmp2_i  = CW'(p.c2);
    vec_a_i = 3'(p.va);
    vec_b_i = 3'(p.vb);
    ord_i   = p.ord[0];
    wr_i    = 1'b1;
  endtask

  // called at the negedge of a pend cycle; checks one period of p.
  // if wr_at >= 0, writes q during that cycle of the period.
  task automatic run_period(input prm_t p, input int wr_at, input prm_t q);
    for (int k = 0; k < 2 * p.per; k++) begin
      int c, e;
      c = (k <= p.per) ? k : 2 * p.per - k;
      e = ref_pat(p, c);
      chk(hs_o == 3'(e), "R3 R4 R5 R7 R10 pattern", int'(hs_o), e);
      chk(ls_o == ~hs_o, "R6 low side", int'(ls_o), int'(~hs_o));
      chk(pend_o == (k == 0), "R2 pend", int'(pend_o), int'(k == 0));
      if (k == wr_at) drive(q);
      @(posedge clk);
      @(negedge clk);
      wr_i = 1'b0;
    end
  endtask

  prm_t none = '{0, 0, 0, 0, 0, 0};

  task automatic apply(input prm_t p);
    while (!pend_o) @(negedge clk);
    drive(p);
    @(negedge clk);
    wr_i = 1'b0;
    @(negedge clk);
    while (!pend_o) @(negedge clk);
    run_period(p, -1, none);
  endtask

  int seq6[6] = '{4, 6, 2, 3, 1, 5};

  initial begin
    prm_t x, y;
    @(negedge clk);
    @(negedge clk);
    // R1: state during reset
    chk(hs_o == 3'b000, "R1 hs reset", int'(hs_o), 0);
    chk(ls_o == 3'b111, "R1 ls reset", int'(ls_o), 7);
    chk(pend_o == 1'b0, "R1 pend reset", int'(pend_o), 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: zero peak after reset, pend every cycle, pattern 000
    for (int i = 0; i < 3; i++) begin
      chk(hs_o == 3'b000, "R1 hs idle", int'(hs_o), 0);
      chk(pend_o == 1'b1, "R1 R2 pend idle", int'(pend_o), 1);
      @(negedge clk);
    end

    // sweep: all thresholds 0..P+1 for small peaks, both orders, every sector
    for (int per = 1; per <= 5; per++)
      for (int a = 0; a <= per + 1; a++)
        for (int b = 0; b <= per + 1; b++)
          for (int o = 0; o < 2; o++) begin
            int sec;
            sec = (a + b + per + o) % 6;
            x = '{per, a, b, seq6[sec], seq6[(sec + 1) % 6], o};
            apply(x);
          end

    // a larger peak at the far end
    x = '{40, 13, 29, 3, 1, 1};
    apply(x);

    // R8: write at the peak of a running period; rest of period unchanged
    x = '{6, 2, 4, 4, 6, 0};
    y = '{5, 1, 3, 2, 3, 1};
    apply(x);
    run_period(x, 6, y);
    run_period(y, -1, none);

    // R9: write in the last cycle, captured on the reload edge itself
    run_period(y, 2 * y.per - 1, x);
    run_period(y, -1, none);
    run_period(x, -1, none);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule